// File: doc/BRIEF.md
# Serial-Loaded Double-Buffered Converter Code Register

This block is the digital front end of a 12-bit serial-loaded converter. A host sends one code word over three wires: a data line, a serial clock and an active-low load strobe. Bits enter a serial-in/parallel-out register on rising serial clock edges, most significant bit first. A second register sits behind it and drives the parallel code output. That output stands in for the converter's switch array.

The second register acts as a level-sensitive transparent latch. While the strobe is low, it follows the first register. When the strobe rises, it freezes the code, and further shifting leaves the output alone until the next strobe. The three serial inputs are asynchronous to the block, so they pass through a synchronizer clocked by the system clock and are acted on in sampled form. Edge detection on the sampled serial clock gives one shift per rising edge. If a host sends more bits than the register holds, only the last twelve count.

Top module: `serial_code_latch`

## Requirements
- R1: While reset is asserted, and right after it is released, the code output is zero and the serial register holds zero.
- R2: Each sampled rising edge of the serial clock with the strobe high shifts the data bit into the serial register's least significant end. Twelve such bits followed by a strobe pulse put the word on the code output, with the first bit sent at bit 11 and the last at bit 0.
- R3: When more than twelve bits are clocked in, the leading extra bits are pushed out and lost. A strobe then presents only the last twelve bits.
- R4: While the sampled strobe is low, the code output equals the serial register contents one system clock later.
- R5: While the sampled strobe is high, the code output does not change, whatever happens on the data or serial clock lines.
- R6: While the sampled strobe is low, rising serial clock edges do not shift the serial register.
- R7: When the strobe rise and a serial clock rise are sampled on the same system clock edge, the code output keeps the word it held before that edge, and the serial register still takes the new bit.
- R8: A strobe fall that is set up before a system clock edge shows on the code output after the third rising system clock edge. That is two synchronizer stages plus the register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the serial lines |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sclk | input | 1 | Serial clock; a rising edge shifts one bit while the strobe is high |
| sdin | input | 1 | Serial data, most significant bit first |
| load_n | input | 1 | Active-low level-sensitive strobe that opens the output register |
| code_o | output | 12 | Parallel code held by the output register; bit 11 carries the largest weight |

## Verification
Two operations can occur on the same edge. One is a serial clock rise that shifts a bit. The other is a strobe rise that closes the output register. The bench provokes this by changing the strobe and the serial clock in the same time step, so both are sampled together. It then judges two results. The code output must keep the previous word. A later strobe must show that the serial register took the new bit, giving the old word shifted left by one with that bit in position 0.

// File: rtl/scl_pkg.sv
package scl_pkg;

  localparam int SER_LINES = 3;

  // Sampled view of the three serial lines.
  typedef struct packed {
    logic sclk;
    logic sdin;
    logic load_n;
  } ser_in_t;

  // Quiet line state: clock low, data low, strobe inactive.
  localparam ser_in_t SER_IDLE = '{sclk: 1'b0, sdin: 1'b0, load_n: 1'b1};

endpackage

// File: rtl/scl_reset_sync.sv
module scl_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = 1'b1;
    end else begin : g_multi
      always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n = chain_q[STAGES-1];

endmodule

// File: rtl/scl_in_sync.sv
module scl_in_sync
  import scl_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  ser_in_t lines_i,
  output ser_in_t lines_o
);

  localparam int CHAIN_W = STAGES * SER_LINES;

  logic [CHAIN_W-1:0] chain_q;
  logic [CHAIN_W-1:0] chain_d;
  logic [CHAIN_W-1:0] chain_rst;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = lines_i;
    end else begin : g_multi
      always_comb chain_d = {chain_q[CHAIN_W-SER_LINES-1:0], lines_i};
    end
  endgenerate

  always_comb chain_rst = {STAGES{SER_IDLE}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= chain_rst;
    else        chain_q <= chain_d;
  end

  assign lines_o = chain_q[CHAIN_W-1 -: SER_LINES];

endmodule

// File: rtl/scl_shift_reg.sv
module scl_shift_reg #(
  parameter int WIDTH = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             bit_i,
  output logic [WIDTH-1:0] word_o
);

  logic [WIDTH-1:0] word_q;
  logic [WIDTH-1:0] word_d;

  // Newest bit enters at bit 0; the oldest leaves from the top.
  always_comb begin
    word_d = word_q;
    if (shift_en) word_d = {word_q[WIDTH-2:0], bit_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        word_q <= '0;
    else if (shift_en) word_q <= word_d;
  end

  assign word_o = word_q;

endmodule

// File: rtl/scl_hold_reg.sv
module scl_hold_reg #(
  parameter int WIDTH = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             open_i,
  input  logic [WIDTH-1:0] word_i,
  output logic [WIDTH-1:0] code_o
);

  logic [WIDTH-1:0] code_q;
  logic [WIDTH-1:0] code_d;

  always_comb begin
    code_d = code_q;
    if (open_i) code_d = word_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      code_q <= '0;
    else if (open_i) code_q <= code_d;
  end

  assign code_o = code_q;

endmodule

// File: rtl/serial_code_latch.sv
module serial_code_latch
  import scl_pkg::*;
#(
  parameter int CODE_W      = 12,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              sclk,
  input  logic              sdin,
  input  logic              load_n,
  output logic [CODE_W-1:0] code_o
);

  localparam int WORD_MSB = CODE_W - 1;

  logic              rst_q;
  ser_in_t           raw_lines;
  ser_in_t           smp;
  logic              sclk_prev_q;
  logic              sclk_prev_d;
  logic              sclk_rise;
  logic              shift_en;
  logic              hold_open;
  logic [WORD_MSB:0] shift_q;

  scl_reset_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (arst_n),
    .rst_n  (rst_q)
  );

  always_comb begin
    raw_lines.sclk   = sclk;
    raw_lines.sdin   = sdin;
    raw_lines.load_n = load_n;
  end

  scl_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_q),
    .lines_i (raw_lines),
    .lines_o (smp)
  );

  // Edge detect on the sampled serial clock.
  always_comb sclk_prev_d = smp.sclk;

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) sclk_prev_q <= 1'b0;
    else        sclk_prev_q <= sclk_prev_d;
  end

  always_comb begin
    sclk_rise = smp.sclk & ~sclk_prev_q;
    shift_en  = sclk_rise & smp.load_n;   // no shifting while strobe low
    hold_open = ~smp.load_n;              // transparent while strobe low
  end

  scl_shift_reg #(.WIDTH(CODE_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_q),
    .shift_en (shift_en),
    .bit_i    (smp.sdin),
    .word_o   (shift_q)
  );

  scl_hold_reg #(.WIDTH(CODE_W)) u_hold (
    .clk    (clk),
    .rst_n  (rst_q),
    .open_i (hold_open),
    .word_i (shift_q),
    .code_o (code_o)
  );

endmodule

// File: rtl/scl_checker.sv
module scl_checker #(
  parameter int CODE_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load_s,
  input logic              sclk_s,
  input logic              sclk_prev,
  input logic              din_s,
  input logic [CODE_W-1:0] shift_word,
  input logic [CODE_W-1:0] code
);

  logic rise;
  always_comb rise = sclk_s & ~sclk_prev;

  // R1
  reset_zero_chk: assert property (@(posedge clk) !rst_n |-> (code == '0 && shift_word == '0));

  // R2
  shift_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_s && rise) |=> shift_word == {$past(shift_word[CODE_W-2:0]), $past(din_s)});

  // R4
  follow_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_s |=> code == $past(shift_word));

  // R5
  hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_s |=> $stable(code));

  // R6
  no_shift_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_s |=> $stable(shift_word));

  // R7
  coincide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(load_s) && rise) |=> ($stable(code) && shift_word[0] == $past(din_s)));

endmodule

bind serial_code_latch scl_checker #(.CODE_W(CODE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_q),
  .load_s     (smp.load_n),
  .sclk_s     (smp.sclk),
  .sclk_prev  (sclk_prev_q),
  .din_s      (smp.sdin),
  .shift_word (shift_q),
  .code       (code_o)
);

// File: tb/sim_serial_code_latch.sv
`timescale 1ns/1ps
module sim_serial_code_latch;

  logic        clk = 1'b0;
  logic        arst_n;
  logic        sclk;
  logic        sdin;
  logic        load_n;
  logic [11:0] code_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  serial_code_latch u0 (
    .clk    (clk),
    .arst_n (arst_n),
    .sclk   (sclk),
    .sdin   (sdin),
    .load_n (load_n),
    .code_o (code_o)
  );

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: code=%h expected %h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    sdin = b; idle(4);
    sclk = 1'b1; idle(4);
    sclk = 1'b0; idle(4);
  endtask

  task automatic send_word(input logic [11:0] w);
    for (int i = 11; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic pulse_load();
    load_n = 1'b0; idle(6);
    load_n = 1'b1; idle(6);
  endtask

  initial begin
    #1600000;
    errors++;
    $display("FAIL watchdog: code=%h expected completion", code_o);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [11:0] prev;
    logic [11:0] w;
    arst_n = 1'b0; sclk = 1'b0; sdin = 1'b0; load_n = 1'b1;
    idle(5);
    chk("R1 during reset", code_o, 12'h000);
    arst_n = 1'b1;
    idle(6);
    chk("R1 after release", code_o, 12'h000);
    // R1: serial register is zero: opening the strobe leaves zero
    pulse_load();
    chk("R1 shift reg zero", code_o, 12'h000);

    // R2/R5 corner words then a swept set
    prev = 12'h000;
    for (int k = 0; k < 262; k++) begin
      case (k)
        0: w = 12'hFFF; 1: w = 12'h800; 2: w = 12'h001;
        3: w = 12'hAAA; 4: w = 12'h555; 5: w = 12'h000;
        default: w = 12'((k * 1657 + k * k * 3) & 12'hFFF);
      endcase
      send_word(w);
      chk("R5 held while shifting", code_o, prev);
      pulse_load();
      chk("R2 word loaded", code_o, w);
      prev = w;
    end

    // R3: 4 junk leading bits then the word
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    send_word(12'h0F3);
    chk("R5 held before load", code_o, prev);
    pulse_load();
    chk("R3 last twelve kept", code_o, 12'h0F3);

    // R8: latency of strobe fall; R4 transparency
    send_word(12'h9C4);
    load_n = 1'b0;
    idle(2);
    chk("R8 not yet visible", code_o, 12'h0F3);
    idle(1);
    chk("R8 visible on third edge", code_o, 12'h9C4);
    chk("R4 follows while low", code_o, 12'h9C4);

    // R6: edges while strobe low do nothing
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    chk("R6 no shift while low", code_o, 12'h9C4);
    load_n = 1'b1; idle(6);
    send_bit(1'b0);
    pulse_load();
    chk("R6 register untouched", code_o, 12'h388);

    // R7: strobe rise and clock rise sampled together
    send_word(12'h6B1);
    load_n = 1'b0; sdin = 1'b1; idle(6);
    chk("R4 open before coincidence", code_o, 12'h6B1);
    load_n = 1'b1; sclk = 1'b1; idle(6);
    chk("R7 code kept", code_o, 12'h6B1);
    sclk = 1'b0; idle(4);
    pulse_load();
    chk("R7 bit still shifted", code_o, 12'hD63);

    // R5: data and clock noise with strobe high leaves code alone
    for (int i = 0; i < 3; i++) send_bit(i[0]);
    chk("R5 stable after noise", code_o, 12'hD63);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule